// File: doc/BRIEF.md
# Single-Thread Reorder Buffer with Paced Squash Walk

This block keeps the in-flight instructions of one thread in program order. Each slot of a circular buffer holds the instruction's sequence number plus two flags: ready to commit, and squashed. The front end pushes instructions in at the tail. Execution units mark a slot ready by its slot index. The commit stage pops the oldest slot, but only once that slot is ready.

A mispredict or exception raises a squash request that carries a sequence number. The buffer then walks backward from the youngest slot, visiting at most `SQ_W` slots per cycle. Every visited slot whose sequence number is greater than the request's is marked both squashed and ready. The walk ends at the first slot whose sequence number is less than or equal to the request's, or when the oldest slot has been covered. Squashed slots are not removed. They drain through normal retirement, and the commit stage sees them flagged as squashed. New instructions are held off while the walk runs. Retirement keeps going during the walk, so the walk can end early when it meets a slot that is leaving.

Top module: `rob_thread`

## Requirements
- R1: After synchronous reset, `count` is 0, `head_ready`, `head_squashed`, `sq_busy` and `tail_upd` are 0, `ins_ready` is 1, and the first slot written is index 0.
- R2: An insert takes effect only in a cycle with `ins_valid`, `ins_ready` high and `sq_valid` low. `ins_ready` is low when `count` equals `DEPTH`, and an insert attempted while full leaves `count` at `DEPTH`.
- R3: Slots leave in insertion order. `head_seq` shows the oldest held sequence number. Slot indices advance by one modulo `DEPTH` per insert.
- R4: `retire_req` removes the head slot only while `head_ready` is high. Otherwise it changes nothing.
- R5: `head_ready` and `head_squashed` are 0 whenever the buffer is empty.
- R6: A `done_valid` pulse with `done_idx` sets the ready flag of that slot, and it is visible on `head_ready` the next cycle.
- R7: A squash request on an empty buffer does nothing, and `sq_busy` stays low.
- R8: A squash request seen while not busy and not empty raises `sq_busy` the next cycle. The walk visits at most `SQ_W` slots per cycle, youngest first. Without retirement, the walk lasts ceil(M/`SQ_W`) cycles when all M held slots are squashed, and floor(M/`SQ_W`)+1 cycles when it stops on an older slot after squashing M slots.
- R9: Every slot with a sequence number greater than the request's gets its squashed and ready flags set. Slots at or below it keep both flags unchanged.
- R10: The walk stops at the first slot whose sequence number is less than or equal to the request's, or after the oldest slot.
- R11: `tail_upd` pulses high for exactly one cycle, right after the walk step that squashed the youngest slot, and never when no slot was squashed.
- R12: While `sq_busy` is high, `ins_ready` is low, inserts are refused, and further squash requests are ignored.
- R13: Retirement continues during a walk. Each retired slot shortens the walk, so a walk over N slots with one retirement per cycle ends after ceil(N/(`SQ_W`+1)) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number to insert |
| ins_ready | output | 1 | Buffer can take an insert (not full, not walking) |
| done_valid | input | 1 | Mark a slot ready to commit |
| done_idx | input | $clog2(DEPTH) | Slot index to mark |
| retire_req | input | 1 | Pop the head slot if it is ready |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash sequence number; younger slots are squashed |
| head_ready | output | 1 | Head slot exists and is ready |
| head_squashed | output | 1 | Head slot exists and is squashed |
| head_seq | output | SEQ_W | Sequence number of the head slot |
| head_idx | output | $clog2(DEPTH) | Slot index of the head |
| sq_busy | output | 1 | Squash walk in progress |
| count | output | $clog2(DEPTH+1) | Number of occupied slots |
| tail_upd | output | 1 | One-cycle pulse: youngest slot was squashed |

## Verification
The hardest situation to reach from the ports is a walk whose stopping point falls on every possible position relative to the `SQ_W` window, with the ring wrapped across the last index. The bench sweeps every fill level from 1 to `DEPTH` against every split point between kept and squashed slots. It repeats the sweep several times, so the head and tail pointers start at many different ring positions. It alternates request values that fall strictly between two held numbers with values equal to a held number. A separate directed case retires the head every cycle while a walk runs, which shortens the walk. The result is checked against a duration computed arithmetically.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Whether a squash walk is running.
  typedef enum logic {WALK_IDLE = 1'b0, WALK_RUN = 1'b1} walk_state_e;
endpackage

// File: rtl/rob_seq_store.sv
// Sequence number storage: one write port at the tail, one read at the head,
// and SQ_W reads stepping downward from the walk pointer.
module rob_seq_store #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int RD_N  = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [SEQ_W-1:0]           wdata,
  input  logic [AW-1:0]              head_addr,
  input  logic [AW-1:0]              walk_addr,
  output logic [SEQ_W-1:0]           head_data,
  output logic [RD_N-1:0][SEQ_W-1:0] walk_data
);
  logic [SEQ_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign head_data = mem[head_addr];

  for (genvar k = 0; k < RD_N; k++) begin : g_rd
    logic [AW-1:0] a;
    assign a            = walk_addr - AW'(k);
    assign walk_data[k] = mem[a];
  end
endmodule

// File: rtl/rob_flags.sv
// Per-slot ready and squashed flags.
module rob_flags #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_fire,
  input  logic [AW-1:0]    ins_addr,
  input  logic             done_valid,
  input  logic [AW-1:0]    done_idx,
  input  logic [DEPTH-1:0] mark_vec,
  output logic [DEPTH-1:0] rdy,
  output logic [DEPTH-1:0] sqd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy <= '0;
      sqd <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (mark_vec[i]) begin
          rdy[i] <= 1'b1;
          sqd[i] <= 1'b1;
        end
      end
      if (done_valid) rdy[done_idx] <= 1'b1;
      // A fresh slot starts clean; the insert wins over a same-cycle mark.
      if (ins_fire) begin
        rdy[ins_addr] <= 1'b0;
        sqd[ins_addr] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rob_squash_walk.sv
// Backward squash walker: visits up to SQ_W slots per cycle from the youngest.
module rob_squash_walk #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int SQ_W  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [SEQ_W-1:0]           key_in,
  input  logic [AW-1:0]              start_ptr,
  input  logic [CW-1:0]              start_left,
  input  logic                       retire_fire,
  input  logic [SQ_W-1:0][SEQ_W-1:0] walk_seq,
  output logic [AW-1:0]              ptr,
  output logic                       busy,
  output logic [DEPTH-1:0]           mark_vec,
  output logic                       tail_upd
);
  import rob_pkg::*;

  walk_state_e      state;
  logic [SEQ_W-1:0] key;
  logic [CW-1:0]    left;
  logic             first;
  logic [CW-1:0]    n_mark;
  logic             found;
  logic             finish;
  logic [CW:0]      consumed;

  assign busy = (state == WALK_RUN);

  always_comb begin
    logic          cont;
    logic [AW-1:0] idx;
    cont     = busy;
    n_mark   = '0;
    found    = 1'b0;
    mark_vec = '0;
    for (int k = 0; k < SQ_W; k++) begin
      idx = ptr - AW'(k);
      if (cont) begin
        if (CW'(k) < left) begin
          if (walk_seq[k] > key) begin
            n_mark        = n_mark + 1'b1;
            mark_vec[idx] = 1'b1;
          end else begin
            found = 1'b1;
            cont  = 1'b0;
          end
        end else begin
          cont = 1'b0;
        end
      end
    end
  end

  assign consumed = {1'b0, n_mark} + (CW+1)'(retire_fire);
  assign finish   = found || (consumed >= {1'b0, left});

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WALK_IDLE;
      key      <= '0;
      ptr      <= '0;
      left     <= '0;
      first    <= 1'b0;
      tail_upd <= 1'b0;
    end else begin
      tail_upd <= 1'b0;
      if (start) begin
        state <= WALK_RUN;
        key   <= key_in;
        ptr   <= start_ptr;
        left  <= start_left;
        first <= 1'b1;
      end else if (busy) begin
        ptr      <= ptr - AW'(n_mark);
        left     <= finish ? '0 : left - CW'(consumed);
        state    <= finish ? WALK_IDLE : WALK_RUN;
        first    <= 1'b0;
        tail_upd <= first && (n_mark != '0);
      end
    end
  end

  // R11: the tail pulse only follows a cycle in which the walk was running
  a_r11_tail_after_walk: assert property (@(posedge clk) disable iff (rst)
    tail_upd |-> $past(busy));

  // R10: a walk with nothing left to cover ends at the next edge
  a_r10_walk_ends: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && left == '0) |=> !busy);
endmodule

// File: rtl/rob_thread.sv
// Single-thread reorder buffer with a width-limited backward squash walk.
module rob_thread #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int SQ_W  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  output logic             ins_ready,
  input  logic             done_valid,
  input  logic [AW-1:0]    done_idx,
  input  logic             retire_req,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic             head_ready,
  output logic             head_squashed,
  output logic [SEQ_W-1:0] head_seq,
  output logic [AW-1:0]    head_idx,
  output logic             sq_busy,
  output logic [CW-1:0]    count,
  output logic             tail_upd
);
  logic [AW-1:0]              head, tail, walk_ptr;
  logic [DEPTH-1:0]           rdy, sqd, mark_vec;
  logic [SQ_W-1:0][SEQ_W-1:0] walk_seq;
  logic                       ins_fire, retire_fire, sq_start, not_empty;
  logic [CW-1:0]              start_left;

  assign not_empty     = (count != '0);
  assign ins_ready     = (count != CW'(DEPTH)) && !sq_busy;
  assign ins_fire      = ins_valid && ins_ready && !sq_valid;
  assign head_ready    = not_empty && rdy[head];
  assign head_squashed = not_empty && sqd[head];
  assign retire_fire   = retire_req && head_ready;
  assign sq_start      = sq_valid && !sq_busy && not_empty;
  assign start_left    = count - CW'(retire_fire);
  assign head_idx      = head;

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (ins_fire)    tail <= tail + 1'b1;
      if (retire_fire) head <= head + 1'b1;
      case ({ins_fire, retire_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  rob_seq_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .RD_N(SQ_W)) u_store (
    .clk       (clk),
    .we        (ins_fire),
    .waddr     (tail),
    .wdata     (ins_seq),
    .head_addr (head),
    .walk_addr (walk_ptr),
    .head_data (head_seq),
    .walk_data (walk_seq)
  );

  rob_flags #(.DEPTH(DEPTH)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .ins_fire   (ins_fire),
    .ins_addr   (tail),
    .done_valid (done_valid),
    .done_idx   (done_idx),
    .mark_vec   (mark_vec),
    .rdy        (rdy),
    .sqd        (sqd)
  );

  rob_squash_walk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_W(SQ_W)) u_walk (
    .clk         (clk),
    .rst         (rst),
    .start       (sq_start),
    .key_in      (sq_seq),
    .start_ptr   (tail - 1'b1),
    .start_left  (start_left),
    .retire_fire (retire_fire),
    .walk_seq    (walk_seq),
    .ptr         (walk_ptr),
    .busy        (sq_busy),
    .mark_vec    (mark_vec),
    .tail_upd    (tail_upd)
  );

  // R2: occupancy never exceeds the depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4: with no ready head and no insert, occupancy holds
  a_r4_hold_unready: assert property (@(posedge clk) disable iff (rst)
    (!head_ready && !ins_fire) |=> count == $past(count));

  // R7: a squash request on an empty buffer leaves the walker idle
  a_r7_empty_squash: assert property (@(posedge clk) disable iff (rst)
    (sq_valid && !sq_busy && count == '0) |=> !sq_busy);

  // R12: no slot is added while a walk runs
  a_r12_no_insert_busy: assert property (@(posedge clk) disable iff (rst)
    sq_busy |=> count <= $past(count));
endmodule

// File: tb/tb_rob_thread.sv
module tb_rob_thread;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 16;
  localparam int SQ_W  = 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ins_valid = 1'b0;
  logic [SEQ_W-1:0] ins_seq = '0;
  logic             ins_ready;
  logic             done_valid = 1'b0;
  logic [AW-1:0]    done_idx = '0;
  logic             retire_req = 1'b0;
  logic             sq_valid = 1'b0;
  logic [SEQ_W-1:0] sq_seq = '0;
  logic             head_ready, head_squashed, sq_busy, tail_upd;
  logic [SEQ_W-1:0] head_seq;
  logic [AW-1:0]    head_idx;
  logic [CW-1:0]    count;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  rob_thread #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_W(SQ_W)) dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_seq(ins_seq),
    .ins_ready(ins_ready), .done_valid(done_valid), .done_idx(done_idx),
    .retire_req(retire_req), .sq_valid(sq_valid), .sq_seq(sq_seq),
    .head_ready(head_ready), .head_squashed(head_squashed),
    .head_seq(head_seq), .head_idx(head_idx), .sq_busy(sq_busy),
    .count(count), .tail_upd(tail_upd)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int s);
    ins_valid = 1'b1;
    ins_seq   = SEQ_W'(s);
    step();
    ins_valid = 1'b0;
  endtask

  task automatic mark_done(input int idx);
    done_valid = 1'b1;
    done_idx   = AW'(idx);
    step();
    done_valid = 1'b0;
  endtask

  task automatic pop();
    retire_req = 1'b1;
    step();
    retire_req = 1'b0;
  endtask

  task automatic drain_all();
    for (int g = 0; g < 2 * DEPTH && count != 0; g++) begin
      if (!head_ready) mark_done(int'(head_idx));
      pop();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int base;
    step(); step();
    rst = 1'b0;
    step();
    // R1: reset state
    check("R1 count", int'(count), 0);
    check("R1 ins_ready", int'(ins_ready), 1);
    check("R1 sq_busy", int'(sq_busy), 0);
    check("R1 tail_upd", int'(tail_upd), 0);
    check("R1 head_idx", int'(head_idx), 0);
    // R5: empty buffer shows nothing ready
    check("R5 head_ready empty", int'(head_ready), 0);
    check("R5 head_squashed empty", int'(head_squashed), 0);

    // R7: squash on empty is a no-op
    sq_valid = 1'b1; sq_seq = '0;
    step();
    sq_valid = 1'b0;
    check("R7 busy after empty squash", int'(sq_busy), 0);
    step();
    check("R7 busy stays low", int'(sq_busy), 0);

    // R2/R3: fill to full, refused extra insert
    for (int i = 0; i < DEPTH; i++) push(100 + i);
    check("R2 count full", int'(count), DEPTH);
    check("R2 ins_ready full", int'(ins_ready), 0);
    push(999);
    check("R2 insert when full ignored", int'(count), DEPTH);
    // R4: retire on an unready head has no effect
    pop();
    check("R4 count unchanged", int'(count), DEPTH);
    check("R4 head unchanged", int'(head_seq), 100);
    // R6: mark head ready by index
    mark_done(int'(head_idx));
    check("R6 head_ready after done", int'(head_ready), 1);
    check("R6 head not squashed", int'(head_squashed), 0);
    for (int i = 0; i < DEPTH; i++) begin
      check("R3 retire order", int'(head_seq), 100 + i);
      if (!head_ready) mark_done(int'(head_idx));
      pop();
    end
    check("R5 drained count", int'(count), 0);
    check("R5 drained head_ready", int'(head_ready), 0);

    // R12: inserts and squashes refused during a walk; R11 pulse width
    for (int i = 0; i < 4; i++) push(200 + i);
    sq_valid = 1'b1; sq_seq = 16'd199;
    step();
    sq_valid = 1'b0;
    check("R8 busy after start", int'(sq_busy), 1);
    check("R12 ins_ready low while busy", int'(ins_ready), 0);
    ins_valid = 1'b1; ins_seq = 16'd500;
    sq_valid = 1'b1; sq_seq = 16'd0;
    step();
    ins_valid = 1'b0; sq_valid = 1'b0;
    check("R12 insert refused while busy", int'(count), 4);
    check("R11 tail_upd after first step", int'(tail_upd), 1);
    check("R8 still busy (4 slots, width 2)", int'(sq_busy), 1);
    step();
    check("R8 walk done after 2 steps", int'(sq_busy), 0);
    check("R11 tail_upd single pulse", int'(tail_upd), 0);
    step();
    check("R12 second squash ignored", int'(sq_busy), 0);
    for (int i = 0; i < 4; i++) begin
      check("R9 squashed slot ready", int'(head_ready), 1);
      check("R9 squashed slot flagged", int'(head_squashed), 1);
      check("R3 order after squash", int'(head_seq), 200 + i);
      pop();
    end

    // R13: retirement shortens a walk
    for (int i = 0; i < 6; i++) push(300 + i);
    mark_done(int'(head_idx));
    mark_done((int'(head_idx) + 1) % DEPTH);
    sq_valid = 1'b1; sq_seq = 16'd10;
    step();
    sq_valid = 1'b0;
    retire_req = 1'b1;
    step();
    check("R13 busy after first step", int'(sq_busy), 1);
    check("R13 count after first retire", int'(count), 5);
    step();
    retire_req = 1'b0;
    check("R13 walk ended early", int'(sq_busy), 0);
    check("R13 count after second retire", int'(count), 4);
    for (int i = 0; i < 4; i++) begin
      check("R13 remaining squashed", int'(head_squashed), 1);
      check("R13 remaining order", int'(head_seq), 302 + i);
      pop();
    end

    // R8/R9/R10/R11 sweep: every fill level and split point, many ring offsets
    base = 1000;
    for (int rep = 0; rep < 3; rep++) begin
      for (int c = 1; c <= DEPTH; c++) begin
        for (int p = 0; p <= c; p++) begin
          int m, key, exp_steps, n_steps, pulses;
          m = c - p;
          for (int i = 0; i < c; i++) push(base + 2 * i);
          if (p > 0 && (rep % 2 == 1)) key = base + 2 * (p - 1);
          else key = base + 2 * p - 1;
          sq_valid = 1'b1; sq_seq = SEQ_W'(key);
          step();
          sq_valid = 1'b0;
          check("R8 busy raised", int'(sq_busy), 1);
          if (p > 0) exp_steps = m / SQ_W + 1;
          else exp_steps = (c + SQ_W - 1) / SQ_W;
          n_steps = 0;
          pulses  = 0;
          while (sq_busy && n_steps < 40) begin
            step();
            n_steps++;
            if (tail_upd) pulses++;
          end
          step();
          if (tail_upd) pulses++;
          check("R8 walk duration", n_steps, exp_steps);
          check("R11 tail_upd pulses", pulses, (m > 0) ? 1 : 0);
          for (int i = 0; i < c; i++) begin
            check("R3 sweep order", int'(head_seq), base + 2 * i);
            if (i < p) begin
              check("R10 kept slot not ready", int'(head_ready), 0);
              check("R10 kept slot not squashed", int'(head_squashed), 0);
              mark_done(int'(head_idx));
              check("R6 kept slot ready", int'(head_ready), 1);
            end else begin
              check("R9 squashed ready", int'(head_ready), 1);
              check("R9 squashed flag", int'(head_squashed), 1);
            end
            pop();
          end
          check("R5 sweep empty", int'(count), 0);
          base = base + 2 * c + 4;
        end
      end
    end

    drain_all();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule